// File: doc/BRIEF.md
# Two-Level Cell Cache Line Access Sequencer

This block sits between a cache-line request port and a row-organised array of two-bit memory cells. Every cell carries a fast, reliable "soft" bit and a slower "hard" bit that needs a larger programming current. The sequencer turns each line read or write into the sequence of cell steps that the line's bit placement requires, drives the array through those steps, and gathers the sensed bits back into a line.

Two placements are selectable by a static configuration input. In the shared placement (`cfg_split` low) each line uses half of a row's cells: even data bits go into soft bits and odd data bits into hard bits. Every access to such a line therefore takes two steps. In the plane placement (`cfg_split` high) a row holds two whole lines: the even line number uses every soft bit and the odd line number uses every hard bit. Soft-plane lines finish in one step. Hard-plane lines need the two-step sequence, and a hard-plane write also reads back and restores its soft-plane neighbour.

Each array step lasts `STEP_CYC` clock cycles. The request side uses a valid/ready handshake and returns a one-cycle done pulse. Only one request is in flight at a time.

Top module: `mlc_line_seq`

## Requirements
- R1: After reset `req_ready` is 1 and both `rsp_done` and `arr_act` are 0.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. From the next cycle `arr_act` is 1 and `req_ready` stays 0 until the done cycle. A request offered while busy is ignored: it does not change the array or any line's data.
- R3: Each accepted request produces exactly one `rsp_done` pulse, one cycle long. In that cycle `req_ready` is already 1 and `arr_act` is 0. The pulse comes `steps*STEP_CYC` cycles after the first active cycle.
- R4: In plane mode a line with address bit 0 equal to 0 lives in the soft bits. A read is one soft sense step (op 0) and a write is one soft program step (op 3), so the latency from acceptance to done is `STEP_CYC+1` cycles. The hard bits of the row are preserved.
- R5: In plane mode a read of a line with address bit 0 equal to 1 is a soft sense (op 0) followed by a hard sense (op 1). During the hard sense `arr_ref` carries the soft levels that the first sense captured. The data returned is the hard bits.
- R6: In plane mode a write of a line with address bit 0 equal to 1 takes three steps: soft sense (op 0), hard program (op 2), then soft program (op 3) with the soft levels that were sensed. A hard program also forces the soft bit of each enabled cell to the written value. The soft-plane line of the same row must still read back unchanged afterwards.
- R7: In shared mode line L uses the cells of half `L[0]` of its row: cells 0 to N/2-1 for half 0 and the upper cells for half 1. Data bit 2j goes to the soft bit of cell j of that half and data bit 2j+1 goes to its hard bit. `arr_mask` enables exactly those N/2 cells. In plane mode all cells are enabled.
- R8: In shared mode a read is soft sense then hard sense, and a write is hard program then soft program. Both take two steps. In every mode a hard program step is followed directly by a soft program step.
- R9: Within a step, `arr_op`, `arr_row` and `arr_mask` are held for `STEP_CYC` cycles, and `arr_last` is 1 only on the final cycle. A program step commits on that final cycle. The sensed data on `arr_rdata` is taken on that final cycle too. A request issues exactly as many `arr_last` cycles as it has steps.
- R10: In both modes the row addressed is the line number shifted right by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_split | input | 1 | Static placement select: 1 plane mode, 0 shared mode |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 write, 0 read |
| req_line | input | LINE_AW | Line number; bit 0 picks plane or half, upper bits pick the row |
| req_wdata | input | LINE_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | LINE_W | Read data, valid with `rsp_done` after a read |
| arr_act | output | 1 | An array step is in progress |
| arr_op | output | 2 | Step code: 0 soft sense, 1 hard sense, 2 hard program, 3 soft program |
| arr_last | output | 1 | Final cycle of the current step |
| arr_row | output | ROW_AW | Row addressed |
| arr_mask | output | LINE_W | Per-cell enable |
| arr_wdata | output | LINE_W | Per-cell value for a program step |
| arr_ref | output | LINE_W | Soft levels that select the reference for a hard sense |
| arr_rdata | input | LINE_W | Per-cell sensed bit for the current sense step |

## Verification
On every cycle the bound assertions check the handshake and the shape of each step. A taken request must start the array, the sequencer is never ready while the array is active, and the done pulse lasts one cycle and coincides with ready. Step fields stay stable until `arr_last`, a hard program is always followed by a soft program, a hard sense always ends the request, and the mask width matches the mode. The bench scenarios check the rest: that the latency of each line kind matches its step count, that data survives the soft-sense-and-restore path, and that lines sharing a row leave each other intact. They also check that a request offered while busy changes nothing the next read can see.

// File: rtl/mlc_seq_pkg.sv
package mlc_seq_pkg;

  typedef enum logic [1:0] {
    OP_SNS_SOFT = 2'd0,
    OP_SNS_HARD = 2'd1,
    OP_PGM_HARD = 2'd2,
    OP_PGM_SOFT = 2'd3
  } cell_op_e;

  typedef enum logic [1:0] {
    LT_SOFT  = 2'd0,
    LT_HARD  = 2'd1,
    LT_MIXED = 2'd2
  } line_e;

  typedef enum logic [2:0] {
    J_RD_ONE  = 3'd0,
    J_RD_TWO  = 3'd1,
    J_WR_ONE  = 3'd2,
    J_WR_TWO  = 3'd3,
    J_WR_KEEP = 3'd4
  } job_e;

  function automatic job_e pick_job(line_e t, logic wr);
    job_e j;
    if (!wr) j = (t == LT_SOFT) ? J_RD_ONE : J_RD_TWO;
    else if (t == LT_SOFT) j = J_WR_ONE;
    else if (t == LT_HARD) j = J_WR_KEEP;
    else j = J_WR_TWO;
    return j;
  endfunction

  function automatic logic [1:0] job_steps(job_e j);
    logic [1:0] n;
    case (j)
      J_RD_ONE, J_WR_ONE: n = 2'd1;
      J_WR_KEEP:          n = 2'd3;
      default:            n = 2'd2;
    endcase
    return n;
  endfunction

  function automatic logic job_is_write(job_e j);
    return (j == J_WR_ONE) || (j == J_WR_TWO) || (j == J_WR_KEEP);
  endfunction

  function automatic cell_op_e job_op(job_e j, logic [1:0] idx);
    cell_op_e op;
    case (j)
      J_RD_ONE:  op = OP_SNS_SOFT;
      J_RD_TWO:  op = (idx == 2'd0) ? OP_SNS_SOFT : OP_SNS_HARD;
      J_WR_ONE:  op = OP_PGM_SOFT;
      J_WR_TWO:  op = (idx == 2'd0) ? OP_PGM_HARD : OP_PGM_SOFT;
      default:   op = (idx == 2'd0) ? OP_SNS_SOFT :
                      (idx == 2'd1) ? OP_PGM_HARD : OP_PGM_SOFT;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/mlc_line_map.sv
module mlc_line_map
  import mlc_seq_pkg::*;
#(
  parameter int LINE_W  = 16,
  parameter int LINE_AW = 4,
  localparam int HALF   = LINE_W / 2
) (
  input  logic               cfg_split,
  input  logic               wr,
  input  logic [LINE_AW-1:0] line,
  output logic [LINE_AW-2:0] row,
  output logic               half,
  output logic [LINE_W-1:0]  mask,
  output line_e              ltype,
  output job_e               job
);

  localparam logic [LINE_W-1:0] LO_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};
  localparam logic [LINE_W-1:0] HI_MASK = {{HALF{1'b1}}, {HALF{1'b0}}};

  assign row   = line[LINE_AW-1:1];
  assign half  = line[0];
  assign ltype = cfg_split ? (line[0] ? LT_HARD : LT_SOFT) : LT_MIXED;
  assign job   = pick_job(ltype, wr);
  assign mask  = cfg_split ? '1 : (line[0] ? HI_MASK : LO_MASK);

endmodule

// File: rtl/mlc_step_timer.sv
module mlc_step_timer #(
  parameter int STEP_CYC = 3,
  localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic last
);

  logic [CW-1:0] cnt_q;

  assign last = run && (cnt_q == CW'(STEP_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart || !run)   cnt_q <= '0;
    else if (last)              cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/mlc_bit_pack.sv
module mlc_bit_pack
  import mlc_seq_pkg::*;
#(
  parameter int LINE_W = 16,
  localparam int HALF  = LINE_W / 2
) (
  input  line_e              ltype,
  input  logic               half,
  input  logic [LINE_W-1:0]  wdata,
  input  logic [LINE_W-1:0]  soft_rd,
  input  logic [LINE_W-1:0]  hard_rd,
  output logic [LINE_W-1:0]  soft_w,
  output logic [LINE_W-1:0]  hard_w,
  output logic [LINE_W-1:0]  rd_line
);

  logic [HALF-1:0]   il_s, il_h, sel_s, sel_h;
  logic [LINE_W-1:0] il_rd;

  assign sel_s = half ? soft_rd[LINE_W-1:HALF] : soft_rd[HALF-1:0];
  assign sel_h = half ? hard_rd[LINE_W-1:HALF] : hard_rd[HALF-1:0];

  for (genvar j = 0; j < HALF; j++) begin : g_cell
    assign il_s[j]        = wdata[2*j];
    assign il_h[j]        = wdata[2*j+1];
    assign il_rd[2*j]     = sel_s[j];
    assign il_rd[2*j+1]   = sel_h[j];
  end

  always_comb begin
    case (ltype)
      LT_SOFT: begin
        soft_w  = wdata;
        hard_w  = '0;
        rd_line = soft_rd;
      end
      LT_HARD: begin
        soft_w  = '0;
        hard_w  = wdata;
        rd_line = hard_rd;
      end
      default: begin
        soft_w  = half ? {il_s, {HALF{1'b0}}} : {{HALF{1'b0}}, il_s};
        hard_w  = half ? {il_h, {HALF{1'b0}}} : {{HALF{1'b0}}, il_h};
        rd_line = il_rd;
      end
    endcase
  end

endmodule

// File: rtl/mlc_line_seq.sv
module mlc_line_seq
  import mlc_seq_pkg::*;
#(
  parameter int LINE_W   = 16,
  parameter int ROWS     = 8,
  parameter int STEP_CYC = 3,
  localparam int ROW_AW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int LINE_AW = ROW_AW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_split,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [LINE_AW-1:0] req_line,
  input  logic [LINE_W-1:0]  req_wdata,
  output logic               rsp_done,
  output logic [LINE_W-1:0]  rsp_rdata,
  output logic               arr_act,
  output logic [1:0]         arr_op,
  output logic               arr_last,
  output logic [ROW_AW-1:0]  arr_row,
  output logic [LINE_W-1:0]  arr_mask,
  output logic [LINE_W-1:0]  arr_wdata,
  output logic [LINE_W-1:0]  arr_ref,
  input  logic [LINE_W-1:0]  arr_rdata
);

  // decoded request
  logic [ROW_AW-1:0] m_row;
  logic              m_half;
  logic [LINE_W-1:0] m_mask;
  line_e             m_ltype;
  job_e              m_job;

  mlc_line_map #(.LINE_W(LINE_W), .LINE_AW(LINE_AW)) map_i (
    .cfg_split (cfg_split),
    .wr        (req_write),
    .line      (req_line),
    .row       (m_row),
    .half      (m_half),
    .mask      (m_mask),
    .ltype     (m_ltype),
    .job       (m_job)
  );

  // held request state
  logic              busy_q, done_q, half_q;
  logic [1:0]        step_q;
  job_e              job_q;
  line_e             ltype_q;
  logic [ROW_AW-1:0] row_q;
  logic [LINE_W-1:0] mask_q, wdata_q, soft_q, hard_q, rdata_q;

  // named internal events
  logic     accept_w, step_last_w, seq_end_w;
  cell_op_e cur_op;

  assign accept_w = req_valid && !busy_q;
  assign cur_op   = job_op(job_q, step_q);

  mlc_step_timer #(.STEP_CYC(STEP_CYC)) tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy_q),
    .restart (accept_w),
    .last    (step_last_w)
  );

  assign seq_end_w = step_last_w && (step_q == job_steps(job_q) - 2'd1);

  // values as they will be after this cycle's capture
  logic [LINE_W-1:0] soft_nx, hard_nx, soft_w, hard_w, rd_line;
  assign soft_nx = (step_last_w && cur_op == OP_SNS_SOFT) ? arr_rdata : soft_q;
  assign hard_nx = (step_last_w && cur_op == OP_SNS_HARD) ? arr_rdata : hard_q;

  mlc_bit_pack #(.LINE_W(LINE_W)) pack_i (
    .ltype   (ltype_q),
    .half    (half_q),
    .wdata   (wdata_q),
    .soft_rd (soft_nx),
    .hard_rd (hard_nx),
    .soft_w  (soft_w),
    .hard_w  (hard_w),
    .rd_line (rd_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      half_q  <= 1'b0;
      step_q  <= '0;
      job_q   <= J_RD_ONE;
      ltype_q <= LT_SOFT;
      row_q   <= '0;
      mask_q  <= '0;
      wdata_q <= '0;
      soft_q  <= '0;
      hard_q  <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_w) begin
        busy_q  <= 1'b1;
        step_q  <= '0;
        job_q   <= m_job;
        ltype_q <= m_ltype;
        row_q   <= m_row;
        half_q  <= m_half;
        mask_q  <= m_mask;
        wdata_q <= req_wdata;
      end else if (step_last_w) begin
        soft_q <= soft_nx;
        hard_q <= hard_nx;
        if (seq_end_w) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (!job_is_write(job_q)) rdata_q <= rd_line;
        end else begin
          step_q <= step_q + 2'd1;
        end
      end
    end
  end

  always_comb begin
    case (cur_op)
      OP_PGM_HARD: arr_wdata = hard_w;
      OP_PGM_SOFT: arr_wdata = (job_q == J_WR_KEEP) ? soft_q : soft_w;
      default:     arr_wdata = '0;
    endcase
  end

  assign req_ready = !busy_q;
  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
  assign arr_act   = busy_q;
  assign arr_op    = cur_op;
  assign arr_last  = step_last_w;
  assign arr_row   = row_q;
  assign arr_mask  = mask_q;
  assign arr_ref   = soft_q;

endmodule

// File: rtl/mlc_line_seq_chk.sv
module mlc_line_seq_chk #(
  parameter int CELLS  = 16,
  parameter int ROW_AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_split,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              arr_act,
  input logic              arr_last,
  input logic [1:0]        arr_op,
  input logic [ROW_AW-1:0] arr_row,
  input logic [CELLS-1:0]  arr_mask
);

  // R2
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> arr_act);

  // R2
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_act |-> !req_ready);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R3
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (req_ready && !arr_act));

  // R9
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_act && !arr_last) |=> (arr_act && $stable(arr_op) && $stable(arr_row) && $stable(arr_mask)));

  // R8
  hard_then_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_act && arr_last && arr_op == 2'd2) |=> (arr_act && arr_op == 2'd3));

  // R5
  hard_sense_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_act && arr_last && arr_op == 2'd1) |=> rsp_done);

  // R7
  half_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_act && !cfg_split) |-> ($countones(arr_mask) == CELLS / 2));

  // R7
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_act && cfg_split) |-> (&arr_mask));

endmodule

bind mlc_line_seq mlc_line_seq_chk #(.CELLS(LINE_W), .ROW_AW(ROW_AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_split (cfg_split),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .arr_act   (arr_act),
  .arr_last  (arr_last),
  .arr_op    (arr_op),
  .arr_row   (arr_row),
  .arr_mask  (arr_mask)
);

// File: tb/mlc_line_seq_tb_top.sv
module mlc_line_seq_tb_top;

  localparam int W    = 16;
  localparam int ROWS = 8;
  localparam int SC   = 3;
  localparam int RAW  = 3;
  localparam int LAW  = 4;
  localparam int NL   = 2 * ROWS;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_split = 1'b1;
  logic           req_valid = 1'b0;
  logic           req_write = 1'b0;
  logic [LAW-1:0] req_line = '0;
  logic [W-1:0]   req_wdata = '0;
  logic           req_ready, rsp_done, arr_act, arr_last;
  logic [W-1:0]   rsp_rdata, arr_mask, arr_wdata, arr_ref;
  logic [W-1:0]   arr_rdata;
  logic [1:0]     arr_op;
  logic [RAW-1:0] arr_row;

  always #4 clk = ~clk;

  mlc_line_seq #(.LINE_W(W), .ROWS(ROWS), .STEP_CYC(SC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_line(req_line), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .arr_act(arr_act), .arr_op(arr_op), .arr_last(arr_last),
    .arr_row(arr_row), .arr_mask(arr_mask), .arr_wdata(arr_wdata),
    .arr_ref(arr_ref), .arr_rdata(arr_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---- behavioural cell array ----
  logic [W-1:0] a_soft [ROWS];
  logic [W-1:0] a_hard [ROWS];

  always_comb begin
    if (arr_op == 2'd0)      arr_rdata = a_soft[arr_row];
    else if (arr_op == 2'd1) arr_rdata = a_hard[arr_row];
    else                     arr_rdata = '0;
  end

  always @(posedge clk) begin
    if (arr_act && arr_last) begin
      for (int c = 0; c < W; c++) begin
        if (arr_mask[c]) begin
          if (arr_op == 2'd2) begin
            a_hard[arr_row][c] <= arr_wdata[c];
            a_soft[arr_row][c] <= arr_wdata[c];
          end else if (arr_op == 2'd3) begin
            a_soft[arr_row][c] <= arr_wdata[c];
          end
        end
      end
    end
  end

  // ---- cycle reference model ----
  logic [W-1:0] gold [NL];
  int           rem = 0;
  bit           done_m = 1'b0;
  int           cur_line = 0;
  bit           cur_wr = 1'b0;
  int           cur_steps = 0;
  logic [W-1:0] cur_exp = '0;
  int           lasts = 0;

  function automatic int steps_for(bit wr, bit split, int line);
    if (!split) return 2;
    if (line % 2 == 0) return 1;
    return wr ? 3 : 2;
  endfunction

  function automatic string tag_for(bit wr, bit split, int line);
    if (!split) return "R8";
    if (line % 2 == 0) return "R4";
    return wr ? "R6" : "R5";
  endfunction

  function automatic logic [W-1:0] mask_for(bit split, int line);
    logic [W-1:0] m;
    for (int c = 0; c < W; c++)
      m[c] = split || ((c >= W / 2) == (line % 2 == 1));
    return m;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rem = 0;
      done_m = 1'b0;
    end else if (rem > 0) begin
      rem = rem - 1;
      done_m = (rem == 0);
    end else begin
      done_m = 1'b0;
      if (req_valid) begin
        cur_line  = int'(req_line);
        cur_wr    = req_write;
        cur_steps = steps_for(req_write, cfg_split, cur_line);
        rem       = cur_steps * SC;
        lasts     = 0;
        if (req_write) gold[cur_line] = req_wdata;
        else cur_exp = gold[cur_line];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready === (rem == 0), "R2 ready", 32'(req_ready), 32'(rem == 0));
      chk(rsp_done === done_m, {tag_for(cur_wr, cfg_split, cur_line), " R3 done"}, 32'(rsp_done), 32'(done_m));
      if (done_m) begin
        chk(lasts == cur_steps, "R9 step count", 32'(lasts), 32'(cur_steps));
        if (!cur_wr)
          chk(rsp_rdata === cur_exp, cfg_split ? {tag_for(0, 1, cur_line), " data"} : "R7 data",
              32'(rsp_rdata), 32'(cur_exp));
      end
      if (arr_act) begin
        if (arr_last) lasts++;
        chk(arr_row === RAW'(cur_line / 2), "R10 row", 32'(arr_row), 32'(cur_line / 2));
        chk(arr_mask === mask_for(cfg_split, cur_line), "R7 mask", 32'(arr_mask),
            32'(mask_for(cfg_split, cur_line)));
        if (arr_op == 2'd1)
          chk(arr_ref === a_soft[arr_row], "R5 ref", 32'(arr_ref), 32'(a_soft[arr_row]));
      end
    end
  end

  // ---- stimulus ----
  task automatic go_reset(input bit split);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_split = split;
    for (int r = 0; r < ROWS; r++) begin
      a_soft[r] = '0;
      a_hard[r] = '0;
    end
    for (int l = 0; l < NL; l++) gold[l] = '0;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && rsp_done === 1'b0 && arr_act === 1'b0, "R1 reset",
        {29'd0, req_ready, rsp_done, arr_act}, 32'h4);
    rst_n = 1'b1;
  endtask

  task automatic do_req(input bit wr, input int line, input logic [W-1:0] d);
    int lat;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_line = LAW'(line); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == steps_for(wr, cfg_split, line) * SC + 1,
        {tag_for(wr, cfg_split, line), " latency"}, 32'(lat),
        32'(steps_for(wr, cfg_split, line) * SC + 1));
  endtask

  bit finished = 1'b0;

  initial begin
    // plane mode
    go_reset(1'b1);
    do_req(1, 2, 16'hA5C3);          // R4 soft write
    do_req(1, 3, 16'h3C96);          // R6 hard write, restores soft
    do_req(0, 2, '0);                // R6 neighbour preserved
    do_req(0, 3, '0);                // R5 hard read
    do_req(1, 2, 16'h0FF0);          // R4 soft write keeps hard plane
    do_req(0, 3, '0);
    do_req(0, 2, '0);
    do_req(1, 15, 16'hFFFF);         // boundary row
    do_req(1, 14, 16'h0001);
    do_req(0, 15, '0);
    do_req(0, 0, '0);
    // R2: request offered while busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_line = 4'd6; req_wdata = 16'h1234;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_line = 4'd8; req_wdata = 16'hDEAD;
    chk(req_ready === 1'b0, "R2 busy", 32'(req_ready), 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done) @(negedge clk);
    do_req(0, 8, '0);
    do_req(0, 6, '0);

    // shared mode
    go_reset(1'b0);
    do_req(1, 4, 16'hAAAA);
    do_req(1, 5, 16'h5555);
    do_req(0, 4, '0);
    do_req(0, 5, '0);
    do_req(1, 4, 16'hC0DE);
    do_req(0, 5, '0);
    do_req(0, 4, '0);
    do_req(1, 15, 16'hFFFF);
    do_req(0, 14, '0);
    do_req(0, 15, '0);
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule